// File: doc/BRIEF.md
# Unaligned read byte extractor

This block sits on the requesting side of a memory-mapped read path that uses 32-bit data and incrementing bursts. The responder always returns whole 32-bit words. The requester, though, only wants the bytes from its start address onward, and only within the transfer size of each beat. Before each burst the block is loaded with the start address, the transfer size and the beat count. It then tracks the address of every returning beat. For each beat it produces a per-lane valid mask and a data word in which every unwanted lane is forced to zero. It also marks the final beat of the burst.

The read-data beats pass straight through the block with no storage. The output handshake controls the input handshake, so a stalled consumer stalls the responder. Only the first beat of an unaligned word-size burst is trimmed. Every later beat starts on an aligned address, so the block passes all lanes within the size.

Top module: `unaligned_rd_extract`

## Requirements
- R1: After reset the block is idle: `out_valid` and `in_ready` are 0 whatever `in_valid` does, until a burst is configured.
- R2: While idle, a cycle with `cfg_valid` high loads a burst. `cfg_addr` is the start byte address. `cfg_size` selects the bytes per beat: 0 = 1, 1 = 2, 2 = 4, and 3 is handled as 4. `cfg_len` is the number of beats minus one. From the next cycle the block is busy.
- R3: On the first beat of a 4-byte burst, `out_keep[i]` is 1 exactly for the lanes i >= start address bits [1:0]. Lane i carries data bits [8i+7:8i]. For example, a start at 0x01 gives keep 4'b1110.
- R4: Every beat after the first in a 4-byte burst has `out_keep` = 4'b1111.
- R5: For 1- and 2-byte sizes, only the lanes that the beat's own address covers within its size-aligned container are valid. The next beat address is the current address rounded down to the size, plus the size. A 2-byte burst at 0x01 gives keeps 0010, 1100, 0011, 1100.
- R6: Each byte of `out_data` equals the matching byte of `in_data` when its keep bit is 1, and is zero otherwise.
- R7: `out_last` is 1 on beat number `cfg_len`+1. The block goes idle in the cycle after that beat is transferred.
- R8: While busy, `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. A beat advances the address and the beat count only when both `in_valid` and `out_ready` are 1.
- R9: A `cfg_valid` that arrives while a burst is in progress is ignored. The running burst continues with its original address, size and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load a new burst (only taken when idle) |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_size | input | 2 | Bytes per beat code |
| cfg_len | input | LEN_W | Beats minus one |
| in_valid | input | 1 | Read beat from responder valid |
| in_ready | output | 1 | Block accepts the read beat |
| in_data | input | 32 | Full read word from responder |
| out_valid | output | 1 | Trimmed beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 32 | Read word with unwanted lanes zeroed |
| out_keep | output | 4 | One bit per valid byte lane |
| out_last | output | 1 | Final beat of the burst |

## Verification
The bench sends word bursts that start at every offset, checking that a design that masks every beat, or masks none, shows the wrong keep. It also sends 2-byte and 1-byte bursts that start at odd offsets and cross word boundaries. A wrong rounding of the next address would show up there as a keep that is shifted by one lane. Consumer stalls in the middle of a burst expose a counter or address that advances without a transfer, which appears as an early `out_last` or a drifting mask. A configuration pulse sent in the middle of a burst catches a block that reloads while busy.

// File: rtl/unaligned_rd_extract.sv
module unaligned_rd_extract #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [3:0]        out_keep,
  output logic              out_last
);
  localparam int LANES = 4;

  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [LEN_W-1:0]  len_q, cnt_q;

  wire [1:0]        sz_in  = (cfg_size == 2'd3) ? 2'd2 : cfg_size;
  wire [2:0]        nbytes = 3'd1 << size_q;
  wire [ADDR_W-1:0] amask  = {{(ADDR_W-3){1'b0}}, nbytes - 3'd1};
  wire [ADDR_W-1:0] base   = addr_q & ~amask;
  wire [2:0]        lo     = {1'b0, addr_q[1:0]};
  wire [2:0]        hi     = {1'b0, base[1:0]} + nbytes - 3'd1;
  wire              xfer   = busy && in_valid && out_ready;

  assign in_ready  = busy && out_ready;
  assign out_valid = busy && in_valid;
  assign out_last  = busy && (cnt_q == len_q);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign out_keep[i]       = (3'(i) >= lo) && (3'(i) <= hi);
    assign out_data[8*i +: 8] = out_keep[i] ? in_data[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy) begin
      if (cfg_valid) begin
        busy   <= 1'b1;
        addr_q <= cfg_addr;
        size_q <= sz_in;
        len_q  <= cfg_len;
        cnt_q  <= '0;
      end
    end else if (xfer) begin
      if (out_last) busy <= 1'b0;
      else begin
        cnt_q  <= cnt_q + 1'b1;
        addr_q <= base + ADDR_W'(nbytes);
      end
    end
  end

  a_r3_first_word_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt_q == '0 && size_q == 2'd2) |-> out_keep == (4'hF << addr_q[1:0]));
  a_r4_later_word_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt_q != '0 && size_q == 2'd2) |-> out_keep == 4'hF);
  a_r5_keep_within_size: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep != 4'h0 && $countones(out_keep) <= int'(nbytes)));
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_last) |=> (!out_valid && !in_ready));
  a_r8_ready_needs_consumer: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);
  a_r9_cfg_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_valid && !(xfer && out_last)) |=> ($stable(len_q) && $stable(size_q) && busy));
endmodule

// File: tb/tb_unaligned_rd_extract.sv
module tb_unaligned_rd_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [1:0]  cfg_size = '0;
  logic [7:0]  cfg_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last;

  always #2 clk = ~clk;

  unaligned_rd_extract #(.ADDR_W(16), .LEN_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_keep(out_keep), .out_last(out_last));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_busy = 0, m_addr = 0, m_sz = 0, m_len = 0, m_cnt = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one cycle: drive at falling edge, compare, then advance the model
  task automatic step(bit cv, int a, int s, int l, bit iv, logic [31:0] d, bit ordy, string tag);
    int nb, lo_a, hi_a, ba;
    logic [3:0]  ek;
    logic [31:0] ed;
    bit el;
    @(negedge clk);
    cfg_valid = cv; cfg_addr = 16'(a); cfg_size = 2'(s); cfg_len = 8'(l);
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    chk(in_ready == (m_busy != 0 && ordy), m_busy ? "R8" : "R1", {tag, " in_ready"}, in_ready, m_busy != 0 && ordy);
    chk(out_valid == (m_busy != 0 && iv), m_busy ? "R8" : "R1", {tag, " out_valid"}, out_valid, m_busy != 0 && iv);
    if (m_busy != 0 && iv) begin
      nb = 1 << m_sz;
      lo_a = m_addr;
      hi_a = (m_addr / nb) * nb + nb;
      ek = '0; ed = '0;
      for (int i = 0; i < 4; i++) begin
        ba = (m_addr / 4) * 4 + i;
        if (ba >= lo_a && ba < hi_a) begin
          ek[i] = 1'b1;
          ed[8*i +: 8] = d[8*i +: 8];
        end
      end
      el = (m_cnt == m_len);
      chk(out_keep == ek, (m_sz == 2) ? ((m_cnt == 0) ? "R3" : "R4") : "R5", {tag, " keep"}, out_keep, ek);
      chk(out_data == ed, "R6", {tag, " data"}, out_data, ed);
      chk(out_last == el, "R7", {tag, " last"}, out_last, el);
    end
    if (m_busy == 0) begin
      if (cv) begin
        m_busy = 1; m_addr = a & 16'hFFFF; m_sz = (s == 3) ? 2 : s; m_len = l; m_cnt = 0;
      end
    end else if (iv && ordy) begin
      if (m_cnt == m_len) m_busy = 0;
      else begin
        nb = 1 << m_sz;
        m_cnt++;
        m_addr = ((m_addr / nb) * nb + nb) & 16'hFFFF;
      end
    end
  endtask

  task automatic burst(int a, int s, int l, bit stall, string tag);
    step(1, a, s, l, 0, 32'h0, 1, {tag, " R2 cfg"});
    while (m_busy != 0) begin
      bit iv = stall ? bit'($urandom % 4 != 0) : 1'b1;
      bit rd = stall ? bit'($urandom % 3 != 0) : 1'b1;
      step(0, 0, 0, 0, iv, $urandom, rd, tag);
    end
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 1, {tag, " R7 idle after"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 1, "R1 reset idle");

    burst(16'h0001, 2, 3, 0, "R3 word at 0x01");
    burst(16'h0002, 2, 1, 0, "R3 word at 0x02");
    burst(16'h0003, 2, 2, 0, "R3 word at 0x03");
    burst(16'h0010, 2, 2, 0, "R4 aligned word");
    burst(16'h0001, 1, 3, 0, "R5 half at 0x01");
    burst(16'h0003, 0, 2, 0, "R5 byte at 0x03");
    burst(16'h0005, 3, 1, 0, "R2 size3 as word");
    burst(16'h0021, 2, 4, 1, "R8 stalled word");

    step(1, 16'h0042, 1, 5, 0, 32'h0, 1, "R9 start");
    step(0, 0, 0, 0, 1, 32'h1122_3344, 1, "R9 beat0");
    step(1, 16'h0000, 0, 0, 1, 32'h5566_7788, 0, "R9 cfg while busy");
    step(1, 16'h0003, 2, 9, 1, 32'h99AA_BBCC, 1, "R9 cfg while busy");
    while (m_busy != 0) step(0, 0, 0, 0, 1, $urandom, 1, "R9 rest");
    step(0, 0, 0, 0, 1, 32'h0, 1, "R9 idle after");

    for (int k = 0; k < 40; k++)
      burst(int'($urandom % 65536), int'($urandom % 4), int'($urandom % 6), 1, "R5 random");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule